// File: doc/BRIEF.md
# Flash Embedded-Operation Status Poller

This block sits on the host side of a parallel NOR-style flash. Once a program, erase or buffered write has been started on the device, the host pulses `start` with the address to watch and the data byte that was written. The poller then reads the status byte at that address over and over through a simple request/response read port and decides when the operation has finished.

Each status read is judged on two signals. One is the polarity bit, which reads back inverted while a program runs. The other is the toggle bit, which flips on every read while the device is busy. Two failure flags are also watched: an over-time flag and a buffer-abort flag. After either flag is seen, one confirming read is made before a failure is reported. A local poll limit ends the wait if the device never settles. The outcome is given as a two-bit code together with a one-cycle `done` pulse. For a buffered write, the caller must give the last address that was loaded into the buffer.

Top module: `flash_status_poller`

## Requirements
- R1: `rd_req` is a one-cycle pulse carrying the address latched at start. Only one read is outstanding at a time: the next request goes out no earlier than the cycle after the `rd_valid` that answers the previous one. The first request appears in the cycle after the accepted `start`.
- R2: Success (code 0) is declared only when a read has bit 7 equal to bit 7 of the expected byte and bit 6 equal to bit 6 of the previous read of the same operation. The first read of an operation can therefore never complete it.
- R3: A read with bit 5 set (device over-time) that does not already complete under R2 triggers one extra confirming read. If that read does not succeed under R5, the result is code 1.
- R4: A read with bit 1 set (buffer abort) that does not complete under R2 triggers one extra confirming read. If that read fails, the result is code 2. When bits 1 and 5 are both set, code 2 wins.
- R5: The confirming read succeeds (code 0) if its bit 7 matches the expected bit 7, or if its bit 6 equals bit 6 of the read before it.
- R6: When `MAX_POLLS` reads have been taken without success or a raised flag, the result is code 3 (local poll limit).
- R7: `done` is high for exactly one cycle, in the cycle after the `rd_valid` that decides the result. `status` is cleared to 0 by an accepted `start` and otherwise holds its last value until the next accepted `start`.
- R8: A `start` pulse while `busy` is high is ignored. The watched address, the expected byte and the read sequence are not changed.
- R9: After reset, `busy`, `rd_req` and `done` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (accepted only while idle) |
| start_addr | input | ADDR_W | Address whose status is read |
| expect_data | input | 8 | Byte that was written |
| rd_req | output | 1 | One-cycle status read request |
| rd_addr | output | ADDR_W | Address for the read request |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 8 | Status byte returned by the flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 0 success, 1 device over-time, 2 buffer abort, 3 poll limit |

## Verification
The bound checker watches the following on every cycle:
- the request pulse width;
- address stability while busy;
- the one-cycle `done` pulse, and that `done` never appears while busy;
- that `status` does not change while idle;
- that an accepted start launches a read at once;
- that the number of requests per operation never exceeds the poll limit plus the single confirming read.

Which code comes out, and after how many reads, depends on the exact bit history of the status bytes. Only the bench's scripted flash responses show this: toggling versus steady bit 6, an inverted versus true bit 7, abort taking priority over over-time, a confirming read that rescues the operation, and running out of polls.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    CODE_OK      = 2'd0,
    CODE_DEV_TMO = 2'd1,
    CODE_ABORT   = 2'd2,
    CODE_LIMIT   = 2'd3
  } fsp_code_e;

  typedef enum logic [1:0] {
    V_AGAIN  = 2'd0,
    V_FINISH = 2'd1,
    V_FLAG   = 2'd2
  } fsp_verdict_e;

  localparam int BIT_POL   = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_TMO   = 5;
  localparam int BIT_ABORT = 1;
endpackage

// File: rtl/fsp_poll_counter.sv
module fsp_poll_counter #(
  parameter int MAX_POLLS = 1000,
  localparam int CNT_W = $clog2(MAX_POLLS + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc && cnt_q != CNT_W'(MAX_POLLS)) cnt_q <= cnt_q + 1'b1;
  end

  // the read now being judged is the MAX_POLLS-th one
  assign last = (cnt_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/fsp_judge.sv
module fsp_judge
  import fsp_pkg::*;
(
  input  logic [7:0]   sample,
  input  logic         exp_pol,
  input  logic         prev_tog,
  input  logic         have_prev,
  input  logic         confirming,
  input  fsp_code_e    pend_code,
  input  logic         last_poll,
  output fsp_verdict_e verdict,
  output fsp_code_e    code
);
  logic pol_ok, tog_steady;

  assign pol_ok     = (sample[BIT_POL] == exp_pol);
  assign tog_steady = have_prev && (sample[BIT_TOG] == prev_tog);

  always_comb begin
    verdict = V_AGAIN;
    code    = CODE_OK;
    if (confirming) begin
      verdict = V_FINISH;
      code    = (pol_ok || tog_steady) ? CODE_OK : pend_code;
    end else if (pol_ok && tog_steady) begin
      verdict = V_FINISH;
    end else if (sample[BIT_ABORT]) begin
      verdict = V_FLAG;
      code    = CODE_ABORT;
    end else if (sample[BIT_TMO]) begin
      verdict = V_FLAG;
      code    = CODE_DEV_TMO;
    end else if (last_poll) begin
      verdict = V_FINISH;
      code    = CODE_LIMIT;
    end
  end
endmodule

// File: rtl/flash_status_poller.sv
module flash_status_poller
  import fsp_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int MAX_POLLS = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        expect_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status
);
  logic              busy_q, req_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic              exp_pol_q, prev_tog_q, have_prev_q, confirm_q;
  fsp_code_e         pend_q, status_q;
  logic              accept, launch, last_poll;
  fsp_verdict_e      verdict;
  fsp_code_e         code;

  assign launch = !busy_q && start;
  assign accept = busy_q && !req_q && rd_valid;

  fsp_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (launch),
    .inc (accept),
    .last(last_poll)
  );

  fsp_judge u_judge (
    .sample    (rd_data),
    .exp_pol   (exp_pol_q),
    .prev_tog  (prev_tog_q),
    .have_prev (have_prev_q),
    .confirming(confirm_q),
    .pend_code (pend_q),
    .last_poll (last_poll),
    .verdict   (verdict),
    .code      (code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      req_q       <= 1'b0;
      done_q      <= 1'b0;
      addr_q      <= '0;
      exp_pol_q   <= 1'b0;
      prev_tog_q  <= 1'b0;
      have_prev_q <= 1'b0;
      confirm_q   <= 1'b0;
      pend_q      <= CODE_OK;
      status_q    <= CODE_OK;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      if (launch) begin
        busy_q      <= 1'b1;
        req_q       <= 1'b1;
        addr_q      <= start_addr;
        exp_pol_q   <= expect_data[BIT_POL];
        have_prev_q <= 1'b0;
        confirm_q   <= 1'b0;
        status_q    <= CODE_OK;
      end else if (accept) begin
        prev_tog_q  <= rd_data[BIT_TOG];
        have_prev_q <= 1'b1;
        case (verdict)
          V_FINISH: begin
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            status_q <= code;
          end
          V_FLAG: begin
            confirm_q <= 1'b1;
            pend_q    <= code;
            req_q     <= 1'b1;
          end
          default: req_q <= 1'b1;
        endcase
      end
    end
  end

  assign rd_req  = req_q;
  assign rd_addr = addr_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign status  = status_q;
endmodule

// File: rtl/fsp_checker.sv
module fsp_checker #(
  parameter int ADDR_W    = 24,
  parameter int MAX_POLLS = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status
);
  int unsigned reqs;

  always_ff @(posedge clk) begin
    if (rst) reqs <= 0;
    else if (start && !busy) reqs <= 0;
    else if (rd_req) reqs <= reqs + 1;
  end

  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst) rd_req |=> !rd_req);
  // R1
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst) busy |=> (busy -> $stable(rd_addr)));
  // R1
  launch_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (rd_req && busy));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst) (!busy && !start) |=> $stable(status));
  // R6
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst) reqs <= MAX_POLLS + 1);
endmodule

bind flash_status_poller fsp_checker #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_fsp_chk (
  .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .busy(busy), .done(done), .status(status)
);

// File: tb/flash_status_poller_bench.sv
module flash_status_poller_bench;
  localparam int AW = 16;
  localparam int MAXP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0]    expect_data = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [7:0]    rd_data = '0;
  logic          busy, done;
  logic [1:0]    status;

  always #2 clk = ~clk;

  flash_status_poller #(.ADDR_W(AW), .MAX_POLLS(MAXP)) u_flash_status_poller (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .expect_data(expect_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .status(status)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] script[$];
  int lat = 0;
  int reads = 0;
  logic [AW-1:0] watch_addr;
  int addr_errs = 0;
  bit finished = 0;

  // reference model state
  bit m_busy, m_req, m_done;
  int m_status;
  logic [AW-1:0] m_addr;
  bit m_exp;
  int m_n, m_prev, m_flag;

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic flash_drive();
    rd_valid = 1'b0;
    if (lat == 1) begin
      rd_valid = 1'b1;
      rd_data = (script.size() > 0) ? script.pop_front() : 8'h00;
      lat = 0;
    end else if (lat > 1) lat--;
    if (rd_req) begin
      lat = 2;
      reads++;
      if (rd_addr != watch_addr) addr_errs++;
    end
  endtask

  task automatic model_finish(int c);
    m_busy = 0; m_done = 1; m_status = c;
  endtask

  task automatic model_step();
    bit old_req, match, steady;
    old_req = m_req;
    if (rst) begin
      m_busy = 0; m_req = 0; m_done = 0; m_status = 0;
    end else begin
      m_done = 0; m_req = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_req = 1; m_addr = start_addr; m_exp = expect_data[7];
          m_n = 0; m_prev = -1; m_flag = -1; m_status = 0;
        end
      end else if (rd_valid && !old_req) begin
        m_n++;
        match = (rd_data[7] == m_exp);
        steady = (m_prev >= 0) && (int'(rd_data[6]) == m_prev);
        if (m_flag >= 0) model_finish((match || steady) ? 0 : m_flag);
        else if (match && steady) model_finish(0);
        else if (rd_data[1]) begin m_flag = 2; m_req = 1; end
        else if (rd_data[5]) begin m_flag = 1; m_req = 1; end
        else if (m_n >= MAXP) model_finish(3);
        else m_req = 1;
        m_prev = int'(rd_data[6]);
      end
    end
  endtask

  task automatic cycle();
    flash_drive();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(rd_req == m_req, "R1 rd_req", int'(rd_req), int'(m_req));
    if (m_req) check(rd_addr == m_addr, "R1 R8 rd_addr", int'(rd_addr), int'(m_addr));
    check(done == m_done, "R7 done", int'(done), int'(m_done));
    check(int'(status) == m_status, "R2 R3 R4 R5 R6 status", int'(status), m_status);
    check(busy == m_busy, "R8 busy", int'(busy), int'(m_busy));
  endtask

  task automatic run_op(logic [AW-1:0] a, logic [7:0] e, logic [7:0] bytes[$],
                        int exp_code, int exp_reads, string tag, bit poke_busy);
    int n;
    bit seen;
    script = bytes;
    reads = 0; addr_errs = 0; watch_addr = a;
    start = 1; start_addr = a; expect_data = e;
    cycle();
    start = 0;
    seen = 0;
    for (n = 0; n < 200 && !seen; n++) begin
      if (poke_busy && n == 3) begin
        start = 1; start_addr = ~a; expect_data = ~e;
      end
      cycle();
      start = 0;
      if (done) seen = 1;
    end
    check(seen, {tag, " done seen"}, int'(seen), 1);
    check(int'(status) == exp_code, {tag, " code"}, int'(status), exp_code);
    check(reads == exp_reads, {tag, " reads"}, reads, exp_reads);
    check(addr_errs == 0, "R1 address of every read", addr_errs, 0);
    for (int k = 0; k < 3; k++) cycle();
    // R7: code held, no further done
    check(int'(status) == exp_code && !done, "R7 held after done", int'(status), exp_code);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    for (int i = 0; i < 3; i++) cycle();
    rst = 0;
    cycle();
    // R9
    check(!busy && !rd_req && !done && status == 2'd0, "R9 reset state",
          int'({busy, rd_req, done, status}), 0);
    // R2: inverted bit 7 while toggling, then true data with steady bit 6
    run_op(16'h1234, 8'hA5, '{8'h00, 8'h40, 8'h00, 8'hA5}, 0, 4, "R2 program", 0);
    // R2: bit 7 already matches but bit 6 still toggling
    run_op(16'h0100, 8'hA5, '{8'h80, 8'hC0, 8'h80, 8'h80}, 0, 4, "R2 toggle", 0);
    // R2: steady bit 6 with wrong bit 7 is not completion
    run_op(16'h0200, 8'hA5, '{8'h00, 8'h00, 8'h00, 8'h85}, 0, 4, "R2 polarity", 0);
    // R2: expected bit 7 = 0
    run_op(16'h0300, 8'h35, '{8'h80, 8'hC0, 8'h35, 8'h35}, 0, 4, "R2 low bit7", 0);
    // R3: over-time confirmed
    run_op(16'h0400, 8'hA5, '{8'h00, 8'h60, 8'h20}, 1, 3, "R3 timeout", 0);
    // R5: over-time rescued by true data
    run_op(16'h0500, 8'hA5, '{8'h00, 8'h60, 8'hA5}, 0, 3, "R5 rescue data", 0);
    // R4: abort confirmed
    run_op(16'h0600, 8'hA5, '{8'h02, 8'h42}, 2, 2, "R4 abort", 0);
    // R4: abort wins over over-time
    run_op(16'h0700, 8'hA5, '{8'h22, 8'h62}, 2, 2, "R4 priority", 0);
    // R5: abort rescued by steady bit 6
    run_op(16'h0800, 8'hA5, '{8'h02, 8'h02}, 0, 2, "R5 rescue toggle", 0);
    // R6: never settles
    run_op(16'h0900, 8'hA5, '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40},
           3, MAXP, "R6 limit", 0);
    // R8: start while busy is ignored
    run_op(16'h0A0A, 8'hA5, '{8'h00, 8'h40, 8'h00, 8'h40, 8'h40, 8'hC5}, 0, 6, "R8 busy start", 0);
    run_op(16'h0B0B, 8'hA5, '{8'h00, 8'h40, 8'h00, 8'hA5}, 0, 4, "R8 poke", 1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule